// File: doc/BRIEF.md
# I2C Target Register File with Auto-Incrementing Pointer

This block is an I2C target that serves a 64-byte register space through a register pointer that steps forward by itself. It watches the open-drain clock and data lines through synchronizers. It detects START, repeated START and STOP conditions. It answers only its fixed 7-bit device address, 1101000.

In a write transaction, the first byte after the address loads the pointer. Every later byte is stored at the pointer, and the pointer then advances. In a read transaction, bytes come back from the pointer onward for as long as the controller acknowledges them. The pointer survives between transactions, so a read that has no pointer write in front of it continues where the previous access stopped. Pointer arithmetic wraps from 3Fh to 00h.

A local parallel port gives the surrounding logic direct read and write access to the same registers.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After synchronous reset, all 64 registers hold 00h, the pointer is 00h and `sda_oe` is 0 (SDA released).
- R2: The address byte after a START is the device address 1101000 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read), so D0h selects a write and D1h a read. On a matching address byte the block pulls SDA low during the 9th clock.
- R3: When the address bits do not match, the block acknowledges nothing. It stores nothing and does not move the pointer until the next START or STOP, even if a later byte equals D0h.
- R4: In a write, the first byte after the address loads its low 6 bits into the pointer. Each later byte is stored at the pointer. Every byte is acknowledged. A write may end right after the pointer byte, leaving the pointer set for a later read.
- R5: The pointer advances by one after every byte stored or returned, and it wraps from 3Fh to 00h for both reads and writes.
- R6: A read returns bytes starting at the current pointer. Without a pointer write in between, a new read continues from where the last access left the pointer.
- R7: A read burst goes on while the controller answers each byte with ACK (SDA low on the 9th clock). After a NACK (SDA high), the block releases SDA and drives nothing until the next START.
- R8: A repeated START in the middle of a transaction restarts address recognition without a STOP, and it releases SDA.
- R9: The block changes SDA only while SCL is low. It samples SDA on rising SCL edges. A START or STOP is an SDA edge seen while the synchronized SCL is high.
- R10: `loc_rdata` shows the register selected by `loc_addr` at all times. A cycle with `loc_we` high stores `loc_wdata` there.
- R11: A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the I2C lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the SCL wire |
| sda_i | input | 1 | Level of the SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| loc_addr | input | 6 | Local port register index |
| loc_we | input | 1 | Local port write strobe |
| loc_wdata | input | 8 | Local port write data |
| loc_rdata | output | 8 | Contents of the register at `loc_addr` |

## Verification
A wrong pointer cannot be seen directly. It shows up on SDA as the wrong byte in the first read that follows, or as a stored byte landing in the wrong register. The local port shows that second kind of error within one clock of the faulty store.

A wrong engine state shows within one SCL period. It appears as a missing or extra acknowledge in the 9th bit, or as SDA still held after a NACK. The bench checks its model of the register contents against `loc_rdata` on every clock while the bus is idle. It compares each acknowledge and read byte against that model when the byte completes.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_PTR,
        ST_WDATA,
        ST_TX,
        ST_TXACK,
        ST_IGNORE
    } eng_state_t;

    // Events derived from the synchronized bus lines
    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
        logic scl;
    } bus_evt_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/i2c_rf_linesync.sv
module i2c_rf_linesync
    import i2c_rf_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda   = sda_s;
        evt.scl   = scl_s;
    end

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_waddr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [DW-1:0] bus_rdata,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Bus writes win over a local write to the same register in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (loc_we) mem[loc_addr] <= loc_wdata;
            if (bus_we) mem[bus_waddr] <= bus_wdata;
        end
    end

    assign bus_rdata = mem[bus_raddr];
    assign loc_rdata = mem[loc_addr];

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h68,
    parameter int unsigned AW       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    output logic              sda_oe,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [AW-1:0]     ptr_o
);
    localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [3:0]    LAST_BIT = 4'd7;
    localparam logic [3:0]    BYTE_DONE = 4'd8;

    eng_state_t        state, nxt;
    logic [AW-1:0]     ptr;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic              ack_on;
    logic              got_ack;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_in;

    assign rx_byte = shift_in(shreg, evt.sda);
    assign byte_in = evt.rise && (bitcnt == LAST_BIT);
    assign rd_addr = ptr;
    assign ptr_o   = ptr;
    assign wr_en   = (state == ST_WDATA) && byte_in;
    assign wr_addr = ptr;
    assign wr_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            ptr     <= '0;
            shreg   <= '0;
            bitcnt  <= '0;
            ack_on  <= 1'b0;
            got_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.start) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            ack_on  <= 1'b0;
            got_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.stop) begin
            state   <= ST_IDLE;
            ack_on  <= 1'b0;
            got_ack <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (evt.rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= byte_in ? 4'd0 : bitcnt + 4'd1;
                    end
                    if (byte_in) begin
                        if (state == ST_ADDR) begin
                            if (rx_byte[7:1] == DEV_ADDR) begin
                                state <= ST_ACK;
                                nxt   <= rx_byte[0] ? ST_TX : ST_PTR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr   <= rx_byte[AW-1:0];
                            state <= ST_ACK;
                            nxt   <= ST_WDATA;
                        end else begin
                            ptr   <= ptr + PTR_ONE;
                            state <= ST_ACK;
                            nxt   <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (evt.fall) begin
                        if (!ack_on) begin
                            sda_oe <= 1'b1;
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            bitcnt <= '0;
                            if (nxt == ST_TX) begin
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + PTR_ONE;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= nxt;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (evt.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.fall) begin
                        if (bitcnt == BYTE_DONE) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_TXACK;
                        end else begin
                            sda_oe <= ~shreg[BYTE_W-1];
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TXACK: begin
                    if (evt.rise) begin
                        if (!evt.sda) got_ack <= 1'b1;
                        else          state   <= ST_IGNORE;
                    end else if (evt.fall && got_ack) begin
                        got_ack <= 1'b0;
                        shreg   <= {rd_data[BYTE_W-2:0], 1'b0};
                        sda_oe  <= ~rd_data[BYTE_W-1];
                        ptr     <= ptr + PTR_ONE;
                        bitcnt  <= '0;
                        state   <= ST_TX;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int unsigned AW          = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [AW-1:0] loc_addr,
    input  logic          loc_we,
    input  logic [7:0]    loc_wdata,
    output logic [7:0]    loc_rdata
);
    bus_evt_t          evt;
    logic              start_ev, stop_ev, scl_lvl;
    logic [AW-1:0]     rd_addr, wr_addr, ptr;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr_en;

    assign start_ev = evt.start;
    assign stop_ev  = evt.stop;
    assign scl_lvl  = evt.scl;

    i2c_rf_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rf_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .sda_oe  (sda_oe),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ptr_o   (ptr)
    );

    i2c_rf_bank #(.AW(AW), .DW(BYTE_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (wr_en),
        .bus_waddr (wr_addr),
        .bus_wdata (wr_data),
        .bus_raddr (rd_addr),
        .bus_rdata (rd_data),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_oe,
    input logic          scl_lvl,
    input logic          start_ev,
    input logic          stop_ev,
    input logic          wr_en,
    input logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    assert_release_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_lvl);

    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    assert_restart_releases_R8: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == $past(ptr) + STEP));

endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .scl_lvl  (scl_lvl),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .wr_en    (wr_en),
    .ptr      (ptr)
);

// File: tb/i2c_regfile_slave_tb_top.sv
module i2c_regfile_slave_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_oe;
    logic [5:0] loc_addr = '0;
    logic       loc_we = 1'b0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;
    wire        sda_line = m_sda & ~sda_oe;

    i2c_regfile_slave dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .loc_addr  (loc_addr),
        .loc_we    (loc_we),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

    int         checks = 0, fails = 0;
    bit         cmp_en = 1'b0;
    bit         done = 1'b0;
    logic [7:0] model_mem [64];
    int         model_ptr = 0;
    logic [7:0] wbuf [$];
    logic       prev_oe = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock reference comparison, sampled away from both clock edges
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (cmp_en) begin
                chk(loc_rdata == model_mem[loc_addr], "R10 local view vs model", loc_rdata, model_mem[loc_addr]);
                chk(sda_oe == 1'b0, "R11 SDA released while idle", sda_oe, 0);
            end
            if (sda_oe != prev_oe)
                chk(m_scl == 1'b0, "R9 SDA changed while SCL high", m_scl, 0);
            prev_oe = sda_oe;
        end
    end

    task automatic qwait;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start;
        cmp_en = 1'b0;
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b0; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b1; qwait;
        qwait;
        cmp_en = 1'b1;
    endtask

    task automatic send_bit(input bit b);
        m_sda = b; qwait;
        m_scl = 1'b1; qwait;
        qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic recv_bit(output bit b);
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        b = sda_line;
        qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!mack);
    endtask

    task automatic loc_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_addr = a; loc_wdata = d; loc_we = 1'b1;
        model_mem[a] = d;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic i2c_write(input logic [5:0] p);
        bit a;
        bus_start;
        wr_byte(8'hD0, a);
        chk(a, "R2 write address D0h acked", a, 1);
        wr_byte({2'b00, p}, a);
        chk(a, "R4 pointer byte acked", a, 1);
        model_ptr = p;
        foreach (wbuf[k]) begin
            wr_byte(wbuf[k], a);
            chk(a, "R4 data byte acked", a, 1);
            model_mem[model_ptr] = wbuf[k];
            model_ptr = (model_ptr + 1) % 64;
        end
        bus_stop;
    endtask

    task automatic read_loop(input int n, input bit probe);
        logic [7:0] v;
        bit b;
        for (int k = 0; k < n; k++) begin
            rd_byte(v, k < n - 1);
            chk(v == model_mem[model_ptr], "R6 R7 read byte from pointer", v, model_mem[model_ptr]);
            model_ptr = (model_ptr + 1) % 64;
        end
        if (probe) begin
            recv_bit(b);
            chk(b == 1'b1, "R7 SDA released after NACK", b, 1);
        end
    endtask

    task automatic i2c_read_cur(input int n, input bit probe);
        bit a;
        bus_start;
        wr_byte(8'hD1, a);
        chk(a, "R2 read address D1h acked", a, 1);
        read_loop(n, probe);
        bus_stop;
    endtask

    task automatic i2c_read_rand(input logic [5:0] p, input int n);
        bit a;
        bus_start;
        wr_byte(8'hD0, a);
        chk(a, "R2 write address acked", a, 1);
        wr_byte({2'b00, p}, a);
        chk(a, "R4 pointer byte acked", a, 1);
        model_ptr = p;
        bus_start;
        wr_byte(8'hD1, a);
        chk(a, "R8 address after repeated START acked", a, 1);
        read_loop(n, 1'b0);
        bus_stop;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run;
    end

    initial begin
        bit a;
        for (int i = 0; i < 64; i++) model_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents seen through the local port
        chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
        for (int i = 0; i < 64; i++) begin
            loc_addr = 6'(i);
            @(negedge clk);
            chk(loc_rdata == 8'h00, "R1 register cleared by reset", loc_rdata, 0);
        end
        cmp_en = 1'b1;

        // R10: local writes; R1: pointer starts at 00h
        loc_write(6'h00, 8'h3C);
        loc_write(6'h01, 8'h4D);
        loc_write(6'h02, 8'h6E);
        loc_write(6'h10, 8'h5A);
        i2c_read_cur(1, 1'b0);
        chk(model_ptr == 1, "R1 pointer began at 00h", model_ptr, 1);

        // R6: pointer persists between transactions
        i2c_read_cur(2, 1'b0);

        // R4: pointer then data
        wbuf = '{8'hA1, 8'hA2, 8'hA3};
        i2c_write(6'h05);
        loc_addr = 6'h06;

        // R8: repeated START random read; R7 burst with ACKs
        i2c_read_rand(6'h05, 3);

        // R7: NACK then silence
        i2c_read_cur(1, 1'b1);

        // R5: write wrap 3Eh..00h
        wbuf = '{8'h11, 8'h22, 8'h33};
        i2c_write(6'h3E);
        loc_addr = 6'h00;
        @(negedge clk);
        chk(loc_rdata == 8'h33, "R5 write wrapped to 00h", loc_rdata, 8'h33);

        // R5: read wrap 3Fh -> 00h -> 01h
        i2c_read_rand(6'h3F, 3);

        // R3: foreign address ignored until STOP
        bus_start;
        wr_byte(8'hA0, a);
        chk(!a, "R3 foreign address not acked", a, 0);
        wr_byte(8'h00, a);
        chk(!a, "R3 byte after foreign address not acked", a, 0);
        wr_byte(8'hD0, a);
        chk(!a, "R3 D0h without START not acked", a, 0);
        wr_byte(8'h55, a);
        chk(!a, "R3 data after foreign address not acked", a, 0);
        bus_stop;
        loc_addr = 6'h00;
        @(negedge clk);
        chk(loc_rdata == 8'h33, "R3 register untouched", loc_rdata, 8'h33);
        i2c_read_cur(1, 1'b0);

        // R4: pointer-only write sets up a later read
        wbuf = {};
        i2c_write(6'h10);
        i2c_read_cur(2, 1'b1);

        // R11: STOP leaves idle state, checked per clock
        repeat (20) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 idle after STOP", sda_oe, 0);

        finish_run;
    end

endmodule